// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Slice

This block models one programmable logic slice. Two 4-input lookup tables each turn their input group into one result bit, using a 16-bit truth table held in configuration storage. A wide-function multiplexer can join the two tables. In that mode the first output becomes any Boolean function of five inputs: the first input group plus a wide-select line. Each half also has a storage element. Configuration selects whether that element is an edge-triggered flip-flop or a level-sensitive latch. It also selects whether set and reset act synchronously or asynchronously, and whether the clock, the clock enable and the set/reset controls are used true or inverted.

Configuration is written through a small parallel port. The load-enable is raised, words are written one per clock, and the load-enable is then dropped. While the load-enable is high the storage elements are held cleared, so the slice stays idle. Each half offers both its combinational result and its stored result.

Top module: `logic_slice`

## Requirements
- R1: `comb_o[0]` equals bit `in_a` of table A and `comb_o[1]` equals bit `in_b` of table B. The input value is the bit index, with input bit 0 as its least significant bit.
- R2: With control bit 15 (wide mode) set, `comb_o[0]` is table B at index `in_a` when `wide_sel` is 1 and table A at index `in_a` when it is 0. `comb_o[1]` is not affected by wide mode.
- R3: With wide mode clear, `wide_sel` has no effect on either output.
- R4: In flip-flop mode (control bit 5h+0 clear for half h), a half loads its combinational result on the active clock edge when its effective clock enable is 1. It holds its value when the enable is 0.
- R5: In latch mode (control bit 5h+0 set), a half follows its combinational result while the effective clock is high and the enable is 1. It holds its value while the clock is low.
- R6: Reset takes priority over set. With control bit 5h+1 set, set and reset act only at the active edge (flip-flop) or while the gate is open (latch), and they act whatever the clock enable is. With that bit clear, they act at once.
- R7: Control bits 5h+2, 5h+3 and 5h+4 invert, for half h, the clock (a flip-flop then captures on the falling edge), the clock enable, and both the set and reset inputs.
- R8: `cfg_wdata` is written on a rising clock edge only when `cfg_load` and `cfg_we` are both 1. `cfg_sel` 0 writes table A, 1 writes table B, 2 writes the control word, and 3 writes nothing. `reg_o` reads 0 while `cfg_load` is 1 and stays 0 after the load until the next capture.
- R9: An active-low `rst_n` clears both tables, the control word and both storage elements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slice clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configuration load-enable; holds the slice idle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration word select |
| cfg_wdata | input | 16 | Configuration write data |
| in_a | input | 4 | Input group of half 0 |
| in_b | input | 4 | Input group of half 1 |
| wide_sel | input | 1 | Fifth input for wide mode |
| ce | input | 1 | Clock enable |
| set_in | input | 1 | Set control |
| rst_in | input | 1 | Reset control |
| comb_o | output | 2 | Combinational result per half |
| reg_o | output | 2 | Stored result per half |

## Verification
Table and wide-mode results are combinational, so the bench checks them one nanosecond after it changes the inputs, in the low clock phase. A flip-flop result is due on the first active edge after the data is driven. The bench drives in the opposite clock phase and samples one nanosecond after that edge: after the rising edge for a true clock, and after the falling edge for an inverted one. Asynchronous set, reset and load-clear act without any clock edge and are checked at once. Latch transparency is checked inside the high phase, and latch hold is checked inside the low phase.

// File: rtl/logic_slice.sv
module logic_slice #(
  parameter int LUT_K = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_sel,
  input  logic [(1<<LUT_K)-1:0]   cfg_wdata,
  input  logic [LUT_K-1:0]        in_a,
  input  logic [LUT_K-1:0]        in_b,
  input  logic                    wide_sel,
  input  logic                    ce,
  input  logic                    set_in,
  input  logic                    rst_in,
  output logic [1:0]              comb_o,
  output logic [1:0]              reg_o
);
  localparam int TBL      = 1 << LUT_K;
  localparam int CW       = 5;
  localparam int WIDE_BIT = TBL - 1;

  logic [TBL-1:0] tbl_a, tbl_b, ctl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_a <= '0;
      tbl_b <= '0;
      ctl   <= '0;
    end else if (cfg_load && cfg_we) begin
      case (cfg_sel)
        2'd0:    tbl_a <= cfg_wdata;
        2'd1:    tbl_b <= cfg_wdata;
        2'd2:    ctl   <= cfg_wdata;
        default: ;
      endcase
    end
  end

  logic wide_m;
  assign wide_m    = ctl[WIDE_BIT];
  assign comb_o[0] = (wide_m && wide_sel) ? tbl_b[in_a] : tbl_a[in_a];
  assign comb_o[1] = tbl_b[in_b];

  logic       clr;
  logic [1:0] is_latch, is_sync, inv_clk, ce_e, set_e, rst_e;
  assign clr = !rst_n || cfg_load;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic gclk, arst, aset, ff_q, lt_q, d_ff;

    assign is_latch[h] = ctl[h*CW+0];
    assign is_sync[h]  = ctl[h*CW+1];
    assign inv_clk[h]  = ctl[h*CW+2];
    assign ce_e[h]     = ce     ^ ctl[h*CW+3];
    assign set_e[h]    = set_in ^ ctl[h*CW+4];
    assign rst_e[h]    = rst_in ^ ctl[h*CW+4];

    assign gclk = clk ^ inv_clk[h];
    assign arst = !is_sync[h] && rst_e[h];
    assign aset = !is_sync[h] && set_e[h] && !rst_e[h];
    assign d_ff = rst_e[h] ? 1'b0 : set_e[h] ? 1'b1 : ce_e[h] ? comb_o[h] : ff_q;

    always_ff @(posedge gclk or posedge clr or posedge arst or posedge aset) begin
      if (clr)       ff_q <= 1'b0;
      else if (arst) ff_q <= 1'b0;
      else if (aset) ff_q <= 1'b1;
      else           ff_q <= d_ff;
    end

    always_latch begin
      if (clr)       lt_q <= 1'b0;
      else if (arst) lt_q <= 1'b0;
      else if (aset) lt_q <= 1'b1;
      else if (gclk && (rst_e[h] || set_e[h] || ce_e[h]))
        lt_q <= rst_e[h] ? 1'b0 : set_e[h] ? 1'b1 : comb_o[h];
    end

    assign reg_o[h] = is_latch[h] ? lt_q : ff_q;
  end
endmodule

// File: rtl/slice_checker.sv
module slice_checker #(
  parameter int LUT_K = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load,
  input logic             wide_m,
  input logic             wide_sel,
  input logic [LUT_K-1:0] in_a,
  input logic [LUT_K-1:0] in_b,
  input logic [1:0]       comb_o,
  input logic [1:0]       reg_o,
  input logic [1:0]       is_latch,
  input logic [1:0]       is_sync,
  input logic [1:0]       inv_clk,
  input logic [1:0]       ce_e,
  input logic [1:0]       set_e,
  input logic [1:0]       rst_e
);
  a_r8_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |-> reg_o == 2'b00);

  a_r2_wide_same_table: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_m && wide_sel && in_a == in_b) |-> comb_o[0] == comb_o[1]);

  for (genvar h = 0; h < 2; h++) begin : g_chk
    a_r6_async_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_sync[h] && rst_e[h]) |-> reg_o[h] == 1'b0);

    a_r6_sync_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_latch[h] && !inv_clk[h] && is_sync[h] && rst_e[h]) |=> reg_o[h] == 1'b0);

    a_r4_ce_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_latch[h] && !inv_clk[h] && is_sync[h] && !ce_e[h] && !set_e[h] && !rst_e[h] && !cfg_load)
      |=> (cfg_load || reg_o[h] == $past(reg_o[h])));
  end
endmodule

bind logic_slice slice_checker #(.LUT_K(LUT_K)) u_slice_checker (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .wide_m(wide_m),
  .wide_sel(wide_sel), .in_a(in_a), .in_b(in_b), .comb_o(comb_o),
  .reg_o(reg_o), .is_latch(is_latch), .is_sync(is_sync), .inv_clk(inv_clk),
  .ce_e(ce_e), .set_e(set_e), .rst_e(rst_e)
);

// File: tb/test_logic_slice.sv
module test_logic_slice;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, cfg_load, cfg_we, wide_sel, ce, set_in, rst_in;
  logic [1:0]  cfg_sel, comb_o, reg_o;
  logic [15:0] cfg_wdata, ta, tb;
  logic [3:0]  in_a, in_b;
  int checks = 0, errors = 0;

  logic_slice i_logic_slice (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .in_a(in_a), .in_b(in_b),
    .wide_sel(wide_sel), .ce(ce), .set_in(set_in), .rst_in(rst_in),
    .comb_o(comb_o), .reg_o(reg_o)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    @(negedge clk); cfg_load = 1; cfg_we = 1; cfg_sel = 0; cfg_wdata = a;
    @(negedge clk); cfg_sel = 1; cfg_wdata = b;
    @(negedge clk); cfg_sel = 2; cfg_wdata = c;
    @(negedge clk); cfg_we = 0;
    #1 chk("R8 cleared during load", {14'd0, reg_o}, 16'd0);
    cfg_load = 0; ta = a; tb = b;
  endtask

  task automatic capture_ones();
    @(negedge clk); ce = 1; in_a = 4'd1; in_b = 4'd0;
    @(posedge clk); #1;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; cfg_load = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    in_a = 4'hF; in_b = 4'hF; wide_sel = 0; ce = 1; set_in = 0; rst_in = 0;
    #15;
    chk("R9 reset comb", {14'd0, comb_o}, 16'd0);
    chk("R9 reset reg", {14'd0, reg_o}, 16'd0);
    @(negedge clk); rst_n = 1;

    // R1 sweeps over three table pairs
    for (int p = 0; p < 3; p++) begin
      case (p)
        0: load(16'h6996, 16'h8001, 16'h0000);
        1: load(16'hF0A5, 16'h0FF0, 16'h0000);
        default: load(16'h1357, 16'hFEDC, 16'h0000);
      endcase
      for (int i = 0; i < 16; i++) begin
        @(negedge clk); in_a = 4'(i); in_b = 4'(15 - i);
        #1 chk("R1 table A", {15'd0, comb_o[0]}, {15'd0, ta[i]});
        chk("R1 table B", {15'd0, comb_o[1]}, {15'd0, tb[15 - i]});
      end
    end

    // R8 writes ignored without load-enable, and select 3 writes nothing
    @(negedge clk); cfg_we = 1; cfg_sel = 0; cfg_wdata = ~ta;
    @(negedge clk); cfg_sel = 1; cfg_wdata = ~tb;
    @(negedge clk); cfg_load = 1; cfg_sel = 3; cfg_wdata = 16'hFFFF;
    @(negedge clk); cfg_load = 0; cfg_we = 0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); in_a = 4'(i); in_b = 4'(i);
      #1 chk("R8 ignored write A", {15'd0, comb_o[0]}, {15'd0, ta[i]});
      chk("R8 ignored write B", {15'd0, comb_o[1]}, {15'd0, tb[i]});
    end

    // R2 wide mode
    load(16'h6996, 16'hA5C3, 16'h8000);
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk); in_a = 4'(i); in_b = 4'(i); wide_sel = s[0];
        #1 chk("R2 wide out0", {15'd0, comb_o[0]}, {15'd0, (s == 1) ? tb[i] : ta[i]});
        chk("R2 wide out1", {15'd0, comb_o[1]}, {15'd0, tb[i]});
      end
    end

    // R3 select ignored without wide mode
    load(16'h6996, 16'hA5C3, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk); in_a = 4'(i); wide_sel = s[0];
        #1 chk("R3 select ignored", {15'd0, comb_o[0]}, {15'd0, ta[i]});
      end
    end
    wide_sel = 0;

    // R4 flip-flop capture and enable hold
    load(16'h6996, 16'h9669, 16'h0000);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); ce = 1; in_a = 4'(i); in_b = 4'(i);
      @(posedge clk); #1;
      chk("R4 capture half0", {15'd0, reg_o[0]}, {15'd0, ^i[3:0]});
      chk("R4 capture half1", {15'd0, reg_o[1]}, {15'd0, ~^i[3:0]});
    end
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ce = 0; in_a = 4'(i); in_b = 4'(i);
      @(posedge clk); #1 chk("R4 enable low holds", {14'd0, reg_o}, 16'd2);
    end
    ce = 1;

    // R8 clear on load
    capture_ones();
    chk("R8 preload value", {14'd0, reg_o}, 16'd3);
    load(16'h6996, 16'h9669, 16'h0000);
    #2 chk("R8 cleared after load", {14'd0, reg_o}, 16'd0);

    // R6 synchronous set/reset
    load(16'h6996, 16'h9669, 16'h0042);
    capture_ones();
    @(negedge clk); rst_in = 1;
    #1 chk("R6 sync reset waits", {14'd0, reg_o}, 16'd3);
    @(posedge clk); #1 chk("R6 sync reset at edge", {14'd0, reg_o}, 16'd0);
    @(negedge clk); rst_in = 0; set_in = 1; ce = 0; in_a = 4'd0; in_b = 4'd1;
    @(posedge clk); #1 chk("R6 sync set ignores enable", {14'd0, reg_o}, 16'd3);
    @(negedge clk); rst_in = 1;
    @(posedge clk); #1 chk("R6 reset beats set", {14'd0, reg_o}, 16'd0);
    @(negedge clk); rst_in = 0; set_in = 0; ce = 1;

    // R6 asynchronous set/reset
    load(16'h6996, 16'h9669, 16'h0000);
    capture_ones();
    @(negedge clk); rst_in = 1;
    #1 chk("R6 async reset", {14'd0, reg_o}, 16'd0);
    rst_in = 0; set_in = 1;
    #1 chk("R6 async set", {14'd0, reg_o}, 16'd3);
    rst_in = 1;
    #1 chk("R6 async reset priority", {14'd0, reg_o}, 16'd0);
    rst_in = 0; set_in = 0;
    #1 chk("R6 released holds", {14'd0, reg_o}, 16'd0);

    // R7 inverted clock on half 0
    load(16'h6996, 16'h9669, 16'h0004);
    @(posedge clk); #5 in_a = 4'd1; in_b = 4'd1;
    @(negedge clk); #1 chk("R7 falling-edge capture", {15'd0, reg_o[0]}, 16'd1);
    #4 in_a = 4'd0; in_b = 4'd0;
    @(posedge clk); #1 chk("R7 no rising capture", {15'd0, reg_o[0]}, 16'd1);
    chk("R7 true clock half1", {15'd0, reg_o[1]}, 16'd1);

    // R7 inverted enable on half 0
    load(16'h6996, 16'h9669, 16'h0008);
    @(negedge clk); ce = 0; in_a = 4'd1;
    @(posedge clk); #1 chk("R7 inverted enable loads", {15'd0, reg_o[0]}, 16'd1);
    @(negedge clk); ce = 1; in_a = 4'd0;
    @(posedge clk); #1 chk("R7 inverted enable holds", {15'd0, reg_o[0]}, 16'd1);

    // R7 inverted set/reset on half 0, asynchronous
    load(16'h6996, 16'h9669, 16'h0010);
    @(negedge clk); rst_in = 1; set_in = 1; in_a = 4'd1; ce = 1;
    @(posedge clk); #1 chk("R7 idle high controls", {15'd0, reg_o[0]}, 16'd1);
    @(negedge clk); rst_in = 0;
    #1 chk("R7 inverted reset", {15'd0, reg_o[0]}, 16'd0);
    chk("R7 true set half1", {15'd0, reg_o[1]}, 16'd1);
    rst_in = 1; set_in = 0;
    #1 chk("R7 split controls", {14'd0, reg_o}, 16'd1);
    rst_in = 0; set_in = 0;

    // R5 latch on half 0
    load(16'h6996, 16'h9669, 16'h0001);
    @(posedge clk); #2 in_a = 4'd1;
    #1 chk("R5 transparent", {15'd0, reg_o[0]}, 16'd1);
    #2 in_a = 4'd0;
    #1 chk("R5 follows", {15'd0, reg_o[0]}, 16'd0);
    @(negedge clk); #2 in_a = 4'd1;
    #1 chk("R5 holds while low", {15'd0, reg_o[0]}, 16'd0);
    @(posedge clk); #2 chk("R5 opens again", {15'd0, reg_o[0]}, 16'd1);
    ce = 0; in_a = 4'd0;
    #1 chk("R5 enable low holds", {15'd0, reg_o[0]}, 16'd1);
    ce = 1;

    // R9 reset clears configuration
    @(negedge clk); in_a = 4'd1; in_b = 4'd0;
    #1 chk("R9 table live", {14'd0, comb_o}, 16'd3);
    rst_n = 0;
    #1 chk("R9 reset clears tables", {14'd0, comb_o}, 16'd0);
    chk("R9 reset clears storage", {14'd0, reg_o}, 16'd0);
    @(negedge clk); rst_n = 1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule